// File: doc/BRIEF.md
# DMA channel interrupt aggregator

This block gathers per-channel event pulses from a 16-channel DMA engine and turns them into a small set of registers plus one interrupt line. Three event classes are tracked independently: transfer done, error A and error B. Each class owns a sticky pending word, an enable word and a read-only masked view (pending AND enable). The three masked views are ORed per channel into a summary word, whose set bits name the channels that need service, and the interrupt output is high while any summary bit is set.

Software reaches the registers through a single-port access: an address, a write strobe and write data, with the read data returned combinationally for the current address. Pending bits are cleared by writing ones to the pending register of their class. The block also passes through a channel-busy word from the datapath and holds a channel priority word, where zero means every channel has the same priority.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every pending, enable and priority register is zero, every mapped address reads zero while the busy input is zero, and `irq` is low.
- R2: A high bit i on `ev_done`, `ev_erra` or `ev_errb` at a rising clock edge sets pending bit i of that class (done pending at address 7, error A pending at 8, error B pending at 9); the bit stays set until cleared, regardless of the enable word.
- R3: Writing a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit remains set.
- R5: Addresses 1, 2 and 3 return the masked done, error A and error B words, each equal to the class pending word ANDed with its enable word.
- R6: Enable registers at addresses 4 (done), 5 (error A) and 6 (error B) are read/write; bit i set to 1 lets channel i's event of that class reach the masked view, 0 blocks it.
- R7: Address 0 returns the summary word: bit i is 1 when any of the three masked words has bit i set.
- R8: `irq` is high exactly while the summary word is non-zero, changing together with the pending and enable registers.
- R9: Address 11 returns the `busy` input word unchanged, with no clock delay.
- R10: Address 10 is a read/write priority word that only changes on a write to that address; writing 0 selects equal priority.
- R11: Writes to the read-only addresses (0 to 3, 11) and to unmapped addresses (12 to 15) change no register, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address for read and write |
| wr_en | input | 1 | Write strobe, takes effect at the rising edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current address |
| ev_done | input | 16 | Transfer-done event pulses, one bit per channel |
| ev_erra | input | 16 | Error A event pulses, one bit per channel |
| ev_errb | input | 16 | Error B event pulses, one bit per channel |
| busy | input | 16 | Channel running flags from the datapath |
| irq | output | 1 | Interrupt, high while any enabled event is pending |

## Verification
Pending bits, enable words and the priority word change at the first rising edge after the pulse or write that causes them, while the masked words, the summary, `irq` and the read data follow those registers and the address with no further clock delay, and `busy` appears on the read data in the same cycle. The bench therefore drives every input on the falling edge, lets exactly one rising edge pass for a registered effect, and samples one nanosecond after setting the read address, well clear of any rising edge. Collision cases present the pulse and the clearing write on the same falling edge so both land on one rising edge.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] rdata,
  input  logic [NCH-1:0] ev_done,
  input  logic [NCH-1:0] ev_erra,
  input  logic [NCH-1:0] ev_errb,
  input  logic [NCH-1:0] busy,
  output logic           irq
);
  localparam int NCLS   = 3;
  localparam int A_SUM  = 0;
  localparam int A_MSK0 = 1;
  localparam int A_EN0  = 4;
  localparam int A_RAW0 = 7;
  localparam int A_PRIO = 10;
  localparam int A_BUSY = 11;

  logic [NCLS-1:0][NCH-1:0] ev, raw_q, en_q, masked;
  logic [NCH-1:0] prio_q, summary;

  assign ev = {ev_errb, ev_erra, ev_done};

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [NCH-1:0] r, e;
    logic raw_hit, en_hit;
    assign raw_hit = wr_en && (addr == AW'(A_RAW0 + c));
    assign en_hit  = wr_en && (addr == AW'(A_EN0 + c));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) r <= '0;
      else        r <= (r & ~(raw_hit ? wdata : '0)) | ev[c];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      e <= '0;
      else if (en_hit) e <= wdata;

    assign raw_q[c]  = r;
    assign en_q[c]   = e;
    assign masked[c] = r & e;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prio_q <= '0;
    else if (wr_en && addr == AW'(A_PRIO)) prio_q <= wdata;

  assign summary = masked[0] | masked[1] | masked[2];
  assign irq     = |summary;

  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_SUM:      rdata = summary;
      A_MSK0:     rdata = masked[0];
      A_MSK0 + 1: rdata = masked[1];
      A_MSK0 + 2: rdata = masked[2];
      A_EN0:      rdata = en_q[0];
      A_EN0 + 1:  rdata = en_q[1];
      A_EN0 + 2:  rdata = en_q[2];
      A_RAW0:     rdata = raw_q[0];
      A_RAW0 + 1: rdata = raw_q[1];
      A_RAW0 + 2: rdata = raw_q[2];
      A_PRIO:     rdata = prio_q;
      A_BUSY:     rdata = busy;
      default:    rdata = '0;
    endcase
  end
endmodule

module dma_irq_agg_chk #(
  parameter int NCH = 16,
  parameter int AW  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        addr,
  input logic                 wr_en,
  input logic [NCH-1:0]       wdata,
  input logic [2:0][NCH-1:0]  ev,
  input logic [2:0][NCH-1:0]  raw,
  input logic [NCH-1:0]       prio,
  input logic                 irq
);
  // R2 and R4: an event always lands, even against a clearing write
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw & $past(ev)) == $past(ev)));

  p_no_spont_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw & ~$past(raw) & ~$past(ev)) == '0));

  p_w1c_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(addr) == AW'(7)) |->
      ((raw[0] & $past(wdata) & ~$past(ev[0])) == '0));

  p_irq_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0));

  p_prio_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(10)) |=> $stable(prio));
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .ev(ev), .raw(raw_q), .prio(prio_q), .irq(irq)
);

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata, ev_done = '0, ev_erra = '0, ev_errb = '0, busy = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .ev_done(ev_done), .ev_erra(ev_erra), .ev_errb(ev_errb),
    .busy(busy), .irq(irq));

  task automatic chk_rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1; checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2);
    @(negedge clk); ev_done = d0; ev_erra = d1; ev_errb = d2;
    @(negedge clk); ev_done = '0; ev_erra = '0; ev_errb = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) chk_rd(4'(a), 16'h0, "R1 reset");
    chk_irq(0, "R1 reset");
  endtask

  task automatic t_enable_rw;
    wr(4, 16'h1234); wr(5, 16'hABCD); wr(6, 16'h0F0F);
    chk_rd(4, 16'h1234, "R6 enable done");
    chk_rd(5, 16'hABCD, "R6 enable erra");
    chk_rd(6, 16'h0F0F, "R6 enable errb");
    wr(4, 0); wr(5, 0); wr(6, 0);
    chk_rd(6, 16'h0, "R6 enable cleared");
  endtask

  task automatic t_sticky;
    wr(4, 16'hFFFF);
    pulse(16'h0005, 0, 0);
    chk_rd(7, 16'h0005, "R2 pending set");
    chk_rd(1, 16'h0005, "R5 masked done");
    chk_rd(0, 16'h0005, "R7 summary");
    chk_irq(1, "R8 irq high");
    repeat (5) @(negedge clk);
    chk_rd(7, 16'h0005, "R2 sticky");
  endtask

  task automatic t_w1c;
    wr(7, 16'h0001);
    chk_rd(7, 16'h0004, "R3 clear one bit");
    wr(7, 16'h0000);
    chk_rd(7, 16'h0004, "R3 zero write no effect");
    wr(7, 16'h0004);
    chk_rd(7, 16'h0000, "R3 clear last bit");
    chk_irq(0, "R8 irq low after clear");
  endtask

  task automatic t_mask;
    wr(5, 16'h00F0);
    pulse(0, 16'h0FF0, 16'h8000);
    chk_rd(8, 16'h0FF0, "R2 erra pending regardless of mask");
    chk_rd(2, 16'h00F0, "R5 masked erra");
    chk_rd(9, 16'h8000, "R2 errb pending while disabled");
    chk_rd(3, 16'h0000, "R6 errb blocked");
    chk_rd(0, 16'h00F0, "R7 summary masked");
    wr(8, 16'hFFFF);
    chk_rd(0, 16'h0000, "R7 summary empty");
    chk_irq(0, "R8 irq low with only disabled pending");
    wr(6, 16'hFFFF);
    chk_rd(0, 16'h8000, "R6 enabling exposes pending");
    chk_irq(1, "R8 irq follows enable");
    wr(9, 16'h8000);
    chk_irq(0, "R8 irq low");
  endtask

  task automatic t_collide;
    pulse(16'h0009, 0, 0);
    chk_rd(7, 16'h0009, "R4 setup");
    @(negedge clk); addr = 7; wdata = 16'h0009; wr_en = 1; ev_done = 16'h0008;
    @(negedge clk); wr_en = 0; ev_done = 0;
    chk_rd(7, 16'h0008, "R4 event wins over clear");
    wr(7, 16'h0008);
    chk_rd(7, 16'h0000, "R4 cleared afterwards");
  endtask

  task automatic t_merge;
    pulse(16'h0002, 16'h0002, 16'h0004);
    chk_rd(0, 16'h0006, "R7 merged summary");
    chk_rd(1, 16'h0002, "R5 masked done merge");
    chk_rd(3, 16'h0004, "R5 masked errb merge");
    chk_irq(1, "R8 irq merged");
    wr(7, 16'hFFFF); wr(8, 16'hFFFF);
    chk_rd(0, 16'h0004, "R7 errb only");
    wr(9, 16'hFFFF);
    chk_irq(0, "R8 all cleared");
  endtask

  task automatic t_busy;
    @(negedge clk); busy = 16'hA5A5;
    chk_rd(11, 16'hA5A5, "R9 busy pass");
    busy = 16'h0180; #1;
    checks++;
    if (rdata !== 16'h0180) begin
      fails++; $display("FAIL R9 busy immediate actual=%h expected=%h", rdata, 16'h0180);
    end
  endtask

  task automatic t_prio;
    wr(10, 16'h1234);
    chk_rd(10, 16'h1234, "R10 prio write");
    wr(10, 16'h0000);
    chk_rd(10, 16'h0000, "R10 equal priority");
  endtask

  task automatic t_ro_ignore;
    wr(10, 16'h00C3);
    pulse(16'h0010, 0, 0);
    for (int a = 0; a < 4; a++) wr(4'(a), 16'hFFFF);
    wr(11, 16'hFFFF);
    for (int a = 12; a < 16; a++) wr(4'(a), 16'hFFFF);
    chk_rd(7, 16'h0010, "R11 pending untouched");
    chk_rd(4, 16'hFFFF, "R11 enable untouched");
    chk_rd(5, 16'h00F0, "R11 enable erra untouched");
    chk_rd(10, 16'h00C3, "R11 prio untouched");
    for (int a = 12; a < 16; a++) chk_rd(4'(a), 16'h0, "R11 unmapped reads zero");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_enable_rw;
    t_sticky;
    t_w1c;
    t_mask;
    t_collide;
    t_merge;
    t_busy;
    t_prio;
    t_ro_ignore;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule